// File: doc/BRIEF.md
# Iterative Integer Divider with Fixed Corner Results

This block computes the quotient of two integers over many clock cycles. An operation is launched with a one-cycle `start_i` pulse. Alongside the pulse the caller supplies a numerator, a denominator, a signedness bit and a width bit. The block sends back the quotient together with a one-cycle `done_o` pulse. It has no remainder output, raises no exception and carries no status flag. The two troublesome operand pairs (a zero divisor, and the most negative signed value divided by minus one) each produce a fixed quotient in a single cycle.

Signed operations are reduced to unsigned ones. The block takes operand magnitudes and feeds them to a radix-2 restoring core that retires one quotient bit per cycle. It then negates the result at the end when the operand signs differ. The narrow mode uses only the low half of each operand and runs half as many iterations. Only one operation is in flight at a time, and the launch is a plain pulse rather than a handshake. A caller must wait for `done_o` before launching again, because a pulse that arrives while the block is working is dropped.

Top module: `idiv_fixed`

## Requirements
- R1: With `signed_i`=0 and `word_i`=0, the quotient is the unsigned floor of `num_i / den_i` over 64 bits.
- R2: With `signed_i`=1, operands are two's complement and the quotient truncates toward zero. It is negative exactly when the operand signs differ and the magnitude quotient is nonzero.
- R3: A zero divisor gives a quotient of 0 in every mode, and this rule takes precedence over R4.
- R4: With `signed_i`=1, the most negative value divided by minus one gives the most negative value (64-bit: 0x8000000000000000). The unsigned reading of the same bits divides normally.
- R5: Counting the rising edge that samples `start_i` as edge 1, `done_o` goes high after edge 1 for R3 and R4 cases, after edge 66 for a normal 64-bit operation, and after edge 34 for a normal 32-bit operation.
- R6: A `start_i` pulse that arrives while an operation is in progress is ignored: it yields no extra `done_o` and does not alter the result of the running operation.
- R7: `done_o` is high for exactly one cycle per accepted operation. `quot_o` holds that result until a later accepted operation completes.
- R8: With `word_i`=1, only bits 31:0 of each operand are used. R3 and R4 apply at 32 bits (the signed overflow result is 0x0000000080000000), and the 32-bit quotient is zero-extended to 64 bits.
- R9: After reset, `done_o` is 0 and `quot_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch pulse, honoured only when idle |
| signed_i | input | 1 | 1 = two's complement operands, 0 = unsigned |
| word_i | input | 1 | 1 = 32-bit operation on bits 31:0, 0 = 64-bit |
| num_i | input | 64 | Numerator (dividend) |
| den_i | input | 64 | Denominator (divisor) |
| quot_o | output | 64 | Quotient of the last completed operation |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench aims at the operand pairs where a sloppy divider goes wrong. A zero divisor, if not intercepted, would let the restoring core return all ones. The signed minimum over minus one, if it went through the normal path, would come back negated or as a magnitude. Mixed signs whose true quotient is below one would show up as minus one if the divider floored instead of truncating. In narrow mode, the bench loads the upper operand halves with garbage and checks the 32-bit overflow and zero-divisor cases. A design that peeked at the high bits, or tested the corner cases at 64 bits, would return a wrong or sign-extended quotient. The bench also fires a second launch mid-operation and measures every latency, which catches a core that restarts, double-completes or runs the wrong number of iterations.

// File: rtl/idiv_pkg.sv
package idiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } idiv_state_e;
endpackage

// File: rtl/idiv_prep.sv
// Operand conditioning: width selection, sign extraction, magnitudes and
// detection of the two operand pairs that bypass the iterative core.
module idiv_prep #(
  parameter int W = 64
) (
  input  logic         signed_i,
  input  logic         word_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] dvd_mag_o,   // pre-aligned for the core
  output logic [W-1:0] dsr_mag_o,
  output logic         q_neg_o,
  output logic         bypass_o,
  output logic [W-1:0] bypass_val_o
);
  localparam int HALF = W / 2;

  logic [W-1:0] n_ext, d_ext, n_mag, d_mag;
  logic         n_neg, d_neg, d_zero, ovf;

  always_comb begin
    if (word_i) begin
      n_ext = signed_i ? {{HALF{num_i[HALF-1]}}, num_i[HALF-1:0]}
                       : {{HALF{1'b0}}, num_i[HALF-1:0]};
      d_ext = signed_i ? {{HALF{den_i[HALF-1]}}, den_i[HALF-1:0]}
                       : {{HALF{1'b0}}, den_i[HALF-1:0]};
    end else begin
      n_ext = num_i;
      d_ext = den_i;
    end
    n_neg = signed_i & n_ext[W-1];
    d_neg = signed_i & d_ext[W-1];
    n_mag = n_neg ? (~n_ext + 1'b1) : n_ext;
    d_mag = d_neg ? (~d_ext + 1'b1) : d_ext;
    d_zero = (d_ext == '0);
    if (word_i)
      ovf = signed_i && (num_i[HALF-1:0] == {1'b1, {(HALF-1){1'b0}}})
                     && (d_ext == '1);
    else
      ovf = signed_i && (num_i == {1'b1, {(W-1){1'b0}}}) && (d_ext == '1);
  end

  assign dvd_mag_o = word_i ? (n_mag << HALF) : n_mag;
  assign dsr_mag_o = d_mag;
  assign q_neg_o   = n_neg ^ d_neg;
  assign bypass_o  = d_zero | ovf;

  always_comb begin
    if (d_zero)
      bypass_val_o = '0;
    else if (word_i)
      bypass_val_o = {{HALF{1'b0}}, 1'b1, {(HALF-1){1'b0}}};
    else
      bypass_val_o = {1'b1, {(W-1){1'b0}}};
  end
endmodule

// File: rtl/idiv_core.sv
// Radix-2 restoring core: one quotient bit per step. The dividend register
// doubles as the quotient register as bits shift out and results shift in.
module idiv_core #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dsr_i,
  output logic [W-1:0] quo_o
);
  logic [W-1:0] rem_q, acc_q, dsr_q;
  logic [W:0]   trial;
  logic         fits;

  assign trial = {rem_q, acc_q[W-1]} - {1'b0, dsr_q};
  assign fits  = ~trial[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      acc_q <= '0;
      dsr_q <= '0;
    end else if (load_i) begin
      rem_q <= '0;
      acc_q <= dvd_i;
      dsr_q <= dsr_i;
    end else if (step_i) begin
      rem_q <= fits ? trial[W-1:0] : {rem_q[W-2:0], acc_q[W-1]};
      acc_q <= {acc_q[W-2:0], fits};
    end
  end

  assign quo_o = acc_q;

  // R1: partial remainder stays below the divisor on every step
  a_r1_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (rem_q < dsr_q));
  // R3: zero divisors never reach the iterating core
  a_r3_no_zero_dsr: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (dsr_q != '0));
endmodule

// File: rtl/idiv_fix.sv
// Final sign restore and narrow-mode zero extension.
module idiv_fix #(
  parameter int W = 64
) (
  input  logic [W-1:0] mag_i,
  input  logic         neg_i,
  input  logic         word_i,
  output logic [W-1:0] res_o
);
  localparam int HALF = W / 2;
  logic [W-1:0] signed_res;

  assign signed_res = neg_i ? (~mag_i + 1'b1) : mag_i;
  assign res_o = word_i ? {{HALF{1'b0}}, signed_res[HALF-1:0]} : signed_res;
endmodule

// File: rtl/idiv_fixed.sv
module idiv_fixed
  import idiv_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic         word_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] quot_o,
  output logic         done_o
);
  localparam int HALF = W / 2;
  localparam int CW   = $clog2(W + 1);

  idiv_state_e  state_q;
  logic [CW-1:0] cnt_q;
  logic          neg_q, word_q, done_q;
  logic [W-1:0]  quot_q;

  logic [W-1:0]  dvd_mag, dsr_mag, bypass_val, core_quo, fixed_res;
  logic          q_neg, bypass, accept, core_load, core_step;

  idiv_prep #(.W(W)) u_prep (
    .signed_i    (signed_i),
    .word_i      (word_i),
    .num_i       (num_i),
    .den_i       (den_i),
    .dvd_mag_o   (dvd_mag),
    .dsr_mag_o   (dsr_mag),
    .q_neg_o     (q_neg),
    .bypass_o    (bypass),
    .bypass_val_o(bypass_val)
  );

  assign accept    = (state_q == ST_IDLE) && start_i;
  assign core_load = accept && !bypass;
  assign core_step = (state_q == ST_RUN);

  idiv_core #(.W(W)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(core_load),
    .step_i(core_step),
    .dvd_i (dvd_mag),
    .dsr_i (dsr_mag),
    .quo_o (core_quo)
  );

  idiv_fix #(.W(W)) u_fix (
    .mag_i (core_quo),
    .neg_i (neg_q),
    .word_i(word_q),
    .res_o (fixed_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      neg_q   <= 1'b0;
      word_q  <= 1'b0;
      done_q  <= 1'b0;
      quot_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            word_q <= word_i;
            neg_q  <= q_neg;
            if (bypass) begin
              quot_q <= bypass_val;
              done_q <= 1'b1;
            end else begin
              cnt_q   <= word_i ? CW'(HALF) : CW'(W);
              state_q <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CW'(1)) state_q <= ST_FIX;
        end
        ST_FIX: begin
          quot_q  <= fixed_res;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign quot_o = quot_q;
  assign done_o = done_q;

  // R5: bypass operands complete on the very next cycle
  a_r5_bypass_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bypass) |=> done_o);
  // R5: the iteration counter never runs dry while iterating
  a_r5_cnt_live: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> (cnt_q != '0));
  // R6: a launch pulse during iteration produces no completion next cycle
  a_r6_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_RUN) && start_i) |=> !done_o);
  // R7: completion only follows the fix-up step or an accepted bypass
  a_r7_done_src: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past((state_q == ST_FIX) || ((state_q == ST_IDLE) && start_i)));
  // R7: result is held while nothing can update it
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_RUN) || ((state_q == ST_IDLE) && !start_i)) |=> $stable(quot_o));
  // R8: narrow results are zero-extended
  a_r8_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && word_q) |-> (quot_o[W-1:HALF] == '0));
endmodule

// File: tb/tb_idiv_fixed.sv
module tb_idiv_fixed;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        signed_i = 1'b0;
  logic        word_i = 1'b0;
  logic [63:0] num_i = '0;
  logic [63:0] den_i = '0;
  logic [63:0] quot_o;
  logic        done_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [63:0] q;
    int          lat;
    int          t0;
    string       tag;
  } exp_t;
  exp_t sb[$];

  localparam logic [63:0] MIN64 = 64'h8000000000000000;

  idiv_fixed dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
    .word_i(word_i), .num_i(num_i), .den_i(den_i),
    .quot_o(quot_o), .done_o(done_o)
  );

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] ref_div(logic [63:0] n, logic [63:0] d,
                                          bit s, bit w);
    logic [31:0] a, b, r32;
    a = n[31:0];
    b = d[31:0];
    if (w) begin
      if (b == 0) return '0;
      if (s) begin
        if (a == 32'h80000000 && b == 32'hFFFFFFFF) return 64'h80000000;
        r32 = 32'($signed(a) / $signed(b));
        return {32'h0, r32};
      end
      return {32'h0, a / b};
    end
    if (d == 0) return '0;
    if (s) begin
      if (n == MIN64 && d == '1) return MIN64;
      return 64'($signed(n) / $signed(d));
    end
    return n / d;
  endfunction

  function automatic bit is_bypass(logic [63:0] n, logic [63:0] d, bit s, bit w);
    if (w) return (d[31:0] == 0) ||
                  (s && n[31:0] == 32'h80000000 && d[31:0] == 32'hFFFFFFFF);
    return (d == 0) || (s && n == MIN64 && d == '1);
  endfunction

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_int(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: pop and compare on every completion pulse
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (sb.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R6 spurious done: actual 1 expected 0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check64({e.tag, " quotient"}, quot_o, e.q);
        check_int({"R5 latency ", e.tag}, cyc - e.t0, e.lat);
      end
    end
  end

  // Driver: launch one operation, optionally poke start while busy
  task automatic run(logic [63:0] n, logic [63:0] d, bit s, bit w,
                     string tag, bit poke = 1'b0);
    exp_t e;
    logic [63:0] q;
    q = ref_div(n, d, s, w);
    @(negedge clk);
    num_i = n; den_i = d; signed_i = s; word_i = w; start_i = 1'b1;
    e.q = q;
    e.lat = is_bypass(n, d, s, w) ? 1 : (w ? 34 : 66);
    e.t0 = cyc;
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    start_i = 1'b0;
    num_i = ~n; den_i = 64'd3; signed_i = ~s; word_i = ~w;
    if (poke) begin
      repeat (3) @(negedge clk);
      start_i = 1'b1;          // R6: dropped, operation in progress
      num_i = 64'd999; den_i = 64'd0;
      @(negedge clk);
      start_i = 1'b0;
    end
    wait (sb.size() == 0);
    @(negedge clk);
    check_int({"R7 done pulse width ", tag}, int'(done_o), 0);
    repeat (4) @(negedge clk);
    check64({"R7 hold ", tag}, quot_o, q);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check64("R9 reset quot", quot_o, '0);
    check_int("R9 reset done", int'(done_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run(64'd100, 64'd7, 0, 0, "R1 small");
    run('1, 64'd1, 0, 0, "R1 max/1");
    run('1, '1, 0, 0, "R1 max/max");
    run(64'd5, 64'd10, 0, 0, "R1 below one");
    run(64'h123456789ABCDEF0, 64'h1234, 0, 0, "R1 wide");
    run(MIN64, 64'd3, 0, 0, "R1 msb set unsigned");

    run(-64'sd100, 64'd7, 1, 0, "R2 neg/pos");
    run(64'd100, -64'sd7, 1, 0, "R2 pos/neg");
    run(-64'sd100, -64'sd7, 1, 0, "R2 neg/neg");
    run(-64'sd1, 64'd2, 1, 0, "R2 truncate to zero");
    run(MIN64, 64'd1, 1, 0, "R2 min/1");
    run(MIN64, -64'sd2, 1, 0, "R2 min/-2");

    run(64'd12345, 64'd0, 0, 0, "R3 unsigned zero den");
    run(-64'sd5, 64'd0, 1, 0, "R3 signed zero den");
    run(MIN64, 64'd0, 1, 0, "R3 min over zero");

    run(MIN64, '1, 1, 0, "R4 signed overflow");
    run(MIN64, '1, 0, 0, "R4 unsigned same bits");

    run(64'hDEADBEEF00000064, 64'hFFFFFFFF00000007, 0, 1, "R8 unsigned narrow");
    run(64'h12345678FFFFFF9C, 64'h0000000100000007, 1, 1, "R8 signed narrow");
    run(64'h0000000180000000, 64'h00000000FFFFFFFF, 1, 1, "R8 narrow overflow");
    run(64'h0000000000000010, 64'hABCD000000000000, 1, 1, "R8 narrow zero den");
    run(64'h00000000FFFFFFFF, 64'h0000000000000001, 0, 1, "R8 narrow max");

    run(64'd1000, 64'd9, 0, 0, "R6 busy start 64", 1'b1);
    run(64'd1000, 64'd9, 1, 1, "R6 busy start 32", 1'b1);

    repeat (10) @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule